// File: doc/BRIEF.md
# SDRAM Write Burst Terminator

This block drives one SDRAM bank through a single write burst on a row that is already open. A requester gives a start column, a burst length code, the number of words it actually wants written, and a way to end the burst. The block then issues the WRITE, streams the payload words onto the data bus, and ends the burst in the chosen way. It can let a fixed-length burst run out, with the unwanted tail masked. It can cut the burst short with a READ to a second column. It can also close the row with a PRECHARGE once write recovery has elapsed, and then reopen a row with ACTIVE once the precharge period has passed.

Write recovery depends on a clock-period input sampled with the request. A period of 15 ns or more gives one recovery cycle; a shorter period gives two. Auto precharge is offered only for bursts that run to completion, because such a burst cannot be cut short by an explicit PRECHARGE. Requests that make no sense are refused with a one-cycle pulse and no command. Examples are a full-page burst with no way to end it, or a word count outside the burst.

Top module: `sdram_wr_burst_term`

## Requirements
- R1: After reset `ready` is high, the command is NOP, `dq_oe` and `req_reject` are low and `sd_dqm` is all zero.
- R2: `sd_cmd_n` is {CS#,RAS#,CAS#,WE#}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010. NOP is driven in every cycle with no other command.
- R3: A request accepted at a clock edge (`req_valid` with `ready`) puts WRITE on the bus in the following cycle. Its address carries the column in the low bits and bit 10 set to the auto-precharge flag. The wanted words follow in payload order, one per cycle starting in the WRITE cycle, with `dq_oe` high and DQM low, and `data_pop` high in each cycle that consumes a word.
- R4: Mode code 0 (run out) keeps a fixed burst of 2, 4 or 8 cycles (length codes 0, 1, 2; code 3 is full page) on the bus. DQM is high for each cycle past the wanted words. With 2 words in a burst of 2, DQM stays low throughout. Without auto precharge, `ready` rises in the last burst cycle.
- R5: Mode code 2 (read) issues READ to `req_rd_col` in the cycle right after the last wanted word, with `dq_oe` low in that cycle. This holds also when the whole fixed burst was wanted. `ready` is high in the next cycle.
- R6: Mode code 1 (precharge) issues PRECHARGE, with address zero (bit 10 low, this bank only), tWR cycles after the last wanted word. DQM is high in every cycle after that word up to and including the PRECHARGE cycle.
- R7: tWR is 1 cycle when `clk_period_ns` is 15 or more, and 2 cycles when it is below 15.
- R8: ACTIVE with `req_row` follows a precharge by exactly TRP_CYC cycles (TRP_CYC at least 2), with NOP in between. `ready` is high in the cycle after ACTIVE.
- R9: With auto precharge the bank precharges by itself tWR cycles after the last burst cycle, and no PRECHARGE command appears. ACTIVE follows TRP_CYC cycles after that point.
- R10: These requests are refused: full page with mode 0, auto precharge with a mode other than 0, a word count of 0 or above the burst length, and mode code 3. A refused request issues no command, gives a `req_reject` pulse in the next cycle and leaves `ready` high.
- R11: A request accepted in the last cycle of a run-out burst without auto precharge puts its WRITE in the very next cycle, with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_col | input | COL_W | Start column of the write |
| req_rd_col | input | COL_W | Column for a terminating READ |
| req_row | input | ROW_W | Row reopened after a precharge |
| req_blen | input | 2 | Burst length code: 0=2, 1=4, 2=8, 3=full page |
| req_words | input | COL_W+1 | Number of wanted words |
| req_mode | input | 2 | 0 run out, 1 precharge, 2 read, 3 invalid |
| req_autopre | input | 1 | Write with auto precharge |
| clk_period_ns | input | 8 | Clock period in ns, picks tWR |
| wr_data | input | DQ_W | Next payload word (show-ahead) |
| data_pop | output | 1 | Current payload word consumed this cycle |
| ready | output | 1 | A request can be accepted this cycle |
| req_reject | output | 1 | Previous request was refused |
| sd_cmd_n | output | 4 | {CS#,RAS#,CAS#,WE#} |
| sd_addr | output | ADDR_W | Address bus |
| sd_dqm | output | DQ_W/8 | Data mask, one bit per byte |
| dq_oe | output | 1 | Data bus drive enable |
| dq_out | output | DQ_W | Data driven onto the bus |

## Verification
The assertions assume a few things about the inputs. Request fields matter only at the edge where the request is accepted. `wr_data` always shows the next payload word and moves on only after a `data_pop` edge. TRP_CYC is at least two. The bench drives `req_valid` only after it has seen `ready` high and drops it right after the accepting edge. It feeds `wr_data` from a fixed, computed word list indexed by the count of pops. Each job's expected bus activity is laid out cycle by cycle from the burst length, word count, mode and period it was given.

// File: rtl/sdwt_pkg.sv
package sdwt_pkg;

    // Position of the auto-precharge flag in the address bus; the memory decodes it.
    localparam int unsigned AUTO_PRE_BIT = 10;

    // {CS#, RAS#, CAS#, WE#}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } sd_cmd_e;

    typedef enum logic [1:0] {
        BLEN_2    = 2'd0,
        BLEN_4    = 2'd1,
        BLEN_8    = 2'd2,
        BLEN_PAGE = 2'd3
    } blen_e;

    typedef enum logic [1:0] {
        FIN_RUN  = 2'd0,
        FIN_PRE  = 2'd1,
        FIN_READ = 2'd2,
        FIN_BAD  = 2'd3
    } fin_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_BURST,
        PH_RECOV,
        PH_PRE,
        PH_WAIT,
        PH_ACT,
        PH_READ
    } phase_e;

    typedef struct packed {
        fin_e fin;
        logic autopre;
        logic twr_two;
    } job_ctl_t;

    // Short clock periods need a second write-recovery cycle.
    function automatic logic twr_is_two(input logic [7:0] period_ns,
                                        input int unsigned slow_ns);
        return ({24'd0, period_ns} < slow_ns);
    endfunction

endpackage

// File: rtl/sdwt_req_check.sv
module sdwt_req_check
    import sdwt_pkg::*;
#(
    parameter  int COL_W = 9,
    localparam int CNT_W = COL_W + 1
) (
    input  blen_e            blen,
    input  logic [CNT_W-1:0] words,
    input  fin_e             fin,
    input  logic             autopre,
    output logic [CNT_W-1:0] len,
    output logic             ok
);

    always_comb begin
        unique case (blen)
            BLEN_2:  len = CNT_W'(2);
            BLEN_4:  len = CNT_W'(4);
            BLEN_8:  len = CNT_W'(8);
            default: len = CNT_W'(1) << COL_W;
        endcase
    end

    always_comb begin
        ok = 1'b1;
        if (words == '0 || words > len)               ok = 1'b0;
        if (fin == FIN_BAD)                           ok = 1'b0;
        if (blen == BLEN_PAGE && fin == FIN_RUN)      ok = 1'b0;
        if (autopre && fin != FIN_RUN)                ok = 1'b0;
    end

endmodule

// File: rtl/sdwt_seq.sv
module sdwt_seq
    import sdwt_pkg::*;
#(
    parameter  int COL_W   = 9,
    parameter  int ROW_W   = 13,
    parameter  int TRP_CYC = 3,
    localparam int CNT_W   = COL_W + 1,
    localparam int TW      = COL_W + 2,
    localparam int RP_W    = $clog2(TRP_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_ok,
    input  logic [CNT_W-1:0] req_len,
    input  logic [CNT_W-1:0] req_words,
    input  job_ctl_t         req_ctl,
    input  logic [COL_W-1:0] req_col,
    input  logic [COL_W-1:0] req_rd_col,
    input  logic [ROW_W-1:0] req_row,
    output phase_e           phase,
    output logic [TW-1:0]    t,
    output logic [TW-1:0]    len_q,
    output logic [TW-1:0]    words_q,
    output job_ctl_t         ctl_q,
    output logic [COL_W-1:0] col_q,
    output logic [COL_W-1:0] rd_col_q,
    output logic [ROW_W-1:0] row_q,
    output logic             ready,
    output logic             reject
);

    logic [RP_W-1:0] rp_cnt;
    logic            last_word;
    logic            last_beat;
    logic            accept;
    logic            refuse;

    assign last_word = (t == words_q - TW'(1));
    assign last_beat = (t == len_q - TW'(1));

    // Ready in idle, and in the final beat of a plain run-out burst so the
    // next WRITE can follow with no gap.
    assign ready  = (phase == PH_IDLE) ||
                    (phase == PH_BURST && ctl_q.fin == FIN_RUN &&
                     !ctl_q.autopre && last_beat);
    assign accept = ready && req_valid && req_ok;
    assign refuse = ready && req_valid && !req_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            t        <= '0;
            len_q    <= '0;
            words_q  <= '0;
            ctl_q    <= '0;
            col_q    <= '0;
            rd_col_q <= '0;
            row_q    <= '0;
            rp_cnt   <= '0;
            reject   <= 1'b0;
        end else begin
            reject <= refuse;
            if (accept) begin
                phase    <= PH_BURST;
                t        <= '0;
                len_q    <= TW'(req_len);
                words_q  <= TW'(req_words);
                ctl_q    <= req_ctl;
                col_q    <= req_col;
                rd_col_q <= req_rd_col;
                row_q    <= req_row;
            end else begin
                unique case (phase)
                    PH_BURST: begin
                        t <= t + TW'(1);
                        if (ctl_q.fin == FIN_READ) begin
                            if (last_word) phase <= PH_READ;
                        end else if (ctl_q.fin == FIN_PRE) begin
                            if (last_word) phase <= ctl_q.twr_two ? PH_RECOV : PH_PRE;
                        end else if (last_beat) begin
                            if (ctl_q.autopre) phase <= ctl_q.twr_two ? PH_RECOV : PH_PRE;
                            else               phase <= PH_IDLE;
                        end
                    end
                    PH_RECOV: begin
                        t     <= t + TW'(1);
                        phase <= PH_PRE;
                    end
                    PH_PRE: begin
                        rp_cnt <= RP_W'(TRP_CYC - 2);
                        phase  <= PH_WAIT;
                    end
                    PH_WAIT: begin
                        if (rp_cnt == '0) phase  <= PH_ACT;
                        else              rp_cnt <= rp_cnt - RP_W'(1);
                    end
                    PH_ACT:  phase <= PH_IDLE;
                    PH_READ: phase <= PH_IDLE;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/sdwt_drive.sv
module sdwt_drive
    import sdwt_pkg::*;
#(
    parameter  int COL_W  = 9,
    parameter  int ROW_W  = 13,
    parameter  int ADDR_W = 13,
    parameter  int DQ_W   = 16,
    localparam int TW     = COL_W + 2,
    localparam int DQM_W  = DQ_W / 8
) (
    input  phase_e            phase,
    input  logic [TW-1:0]     t,
    input  logic [TW-1:0]     len_q,
    input  logic [TW-1:0]     words_q,
    input  job_ctl_t          ctl_q,
    input  logic [COL_W-1:0]  col_q,
    input  logic [COL_W-1:0]  rd_col_q,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [DQ_W-1:0]   wr_data,
    output sd_cmd_e           cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              oe,
    output logic [DQ_W-1:0]   dq,
    output logic              pop
);

    logic mask;

    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        mask = 1'b0;
        oe   = 1'b0;
        pop  = 1'b0;
        unique case (phase)
            PH_BURST: begin
                if (t == '0) begin
                    cmd                = CMD_WR;
                    addr[COL_W-1:0]    = col_q;
                    addr[AUTO_PRE_BIT] = ctl_q.autopre;
                end
                pop  = (t < words_q);
                oe   = (t < len_q);
                mask = !pop;
            end
            PH_RECOV: begin
                mask = !ctl_q.autopre;
                oe   = !ctl_q.autopre && (t < len_q);
            end
            PH_PRE: begin
                if (!ctl_q.autopre) begin
                    cmd  = CMD_PRE;
                    mask = 1'b1;
                end
            end
            PH_ACT: begin
                cmd             = CMD_ACT;
                addr[ROW_W-1:0] = row_q;
            end
            PH_READ: begin
                cmd             = CMD_RD;
                addr[COL_W-1:0] = rd_col_q;
            end
            default: ;
        endcase
    end

    assign dqm = {DQM_W{mask}};
    assign dq  = pop ? wr_data : '0;

endmodule

// File: rtl/sdram_wr_burst_term.sv
module sdram_wr_burst_term
    import sdwt_pkg::*;
#(
    parameter  int COL_W       = 9,
    parameter  int ROW_W       = 13,
    parameter  int ADDR_W      = 13,
    parameter  int DQ_W        = 16,
    parameter  int TRP_CYC     = 3,
    parameter  int TWR_SLOW_NS = 15,
    localparam int CNT_W       = COL_W + 1,
    localparam int TW          = COL_W + 2,
    localparam int DQM_W       = DQ_W / 8,
    localparam int SP_W        = $clog2(TRP_CYC + 1) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [COL_W-1:0]  req_col,
    input  logic [COL_W-1:0]  req_rd_col,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [1:0]        req_blen,
    input  logic [CNT_W-1:0]  req_words,
    input  logic [1:0]        req_mode,
    input  logic              req_autopre,
    input  logic [7:0]        clk_period_ns,
    input  logic [DQ_W-1:0]   wr_data,
    output logic              data_pop,
    output logic              ready,
    output logic              req_reject,
    output logic [3:0]        sd_cmd_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [DQM_W-1:0]  sd_dqm,
    output logic              dq_oe,
    output logic [DQ_W-1:0]   dq_out
);

    logic [CNT_W-1:0] req_len;
    logic             req_ok;
    job_ctl_t         req_ctl;
    phase_e           phase;
    logic [TW-1:0]    t;
    logic [TW-1:0]    len_q;
    logic [TW-1:0]    words_q;
    job_ctl_t         ctl_q;
    logic [COL_W-1:0] col_q;
    logic [COL_W-1:0] rd_col_q;
    logic [ROW_W-1:0] row_q;
    sd_cmd_e          cmd;

    assign req_ctl.fin     = fin_e'(req_mode);
    assign req_ctl.autopre = req_autopre;
    assign req_ctl.twr_two = twr_is_two(clk_period_ns, TWR_SLOW_NS);

    sdwt_req_check #(.COL_W(COL_W)) chk_i (
        .blen    (blen_e'(req_blen)),
        .words   (req_words),
        .fin     (req_ctl.fin),
        .autopre (req_autopre),
        .len     (req_len),
        .ok      (req_ok)
    );

    sdwt_seq #(.COL_W(COL_W), .ROW_W(ROW_W), .TRP_CYC(TRP_CYC)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ok     (req_ok),
        .req_len    (req_len),
        .req_words  (req_words),
        .req_ctl    (req_ctl),
        .req_col    (req_col),
        .req_rd_col (req_rd_col),
        .req_row    (req_row),
        .phase      (phase),
        .t          (t),
        .len_q      (len_q),
        .words_q    (words_q),
        .ctl_q      (ctl_q),
        .col_q      (col_q),
        .rd_col_q   (rd_col_q),
        .row_q      (row_q),
        .ready      (ready),
        .reject     (req_reject)
    );

    sdwt_drive #(.COL_W(COL_W), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .DQ_W(DQ_W)) drv_i (
        .phase    (phase),
        .t        (t),
        .len_q    (len_q),
        .words_q  (words_q),
        .ctl_q    (ctl_q),
        .col_q    (col_q),
        .rd_col_q (rd_col_q),
        .row_q    (row_q),
        .wr_data  (wr_data),
        .cmd      (cmd),
        .addr     (sd_addr),
        .dqm      (sd_dqm),
        .oe       (dq_oe),
        .dq       (dq_out),
        .pop      (data_pop)
    );

    assign sd_cmd_n = cmd;

    // Cycles since the bank entered precharge (explicit or automatic).
    logic [SP_W-1:0] since_pre;
    always_ff @(posedge clk) begin
        if (rst)                               since_pre <= SP_W'(TRP_CYC);
        else if (phase == PH_PRE)              since_pre <= SP_W'(1);
        else if (since_pre < SP_W'(TRP_CYC))   since_pre <= since_pre + SP_W'(1);
    end

    assert_trp_gap_R8: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd_n == CMD_ACT) |-> (since_pre == SP_W'(TRP_CYC)));

    assert_read_releases_dq_R5: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd_n == CMD_RD) |-> !dq_oe);

    assert_pre_masked_R6: assert property (@(posedge clk) disable iff (rst)
        (sd_cmd_n == CMD_PRE) |-> ((&sd_dqm) && ($past(data_pop) || (&$past(sd_dqm)))));

    assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        ready |-> (sd_cmd_n == CMD_NOP));

    assert_write_follows_accept_R3: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid && req_ok) |=> (sd_cmd_n == CMD_WR));

    assert_page_run_refused_R10: assert property (@(posedge clk) disable iff (rst)
        (ready && req_valid && req_blen == 2'd3 && req_mode == 2'd0) |=> (req_reject && sd_cmd_n == CMD_NOP));

endmodule

// File: tb/sdram_wr_burst_term_tb_top.sv
`timescale 1ns/1ps
module sdram_wr_burst_term_tb_top;

    localparam int TB_TRP = 3;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [8:0]  req_col = '0, req_rd_col = '0;
    logic [12:0] req_row = '0;
    logic [1:0]  req_blen = '0, req_mode = '0;
    logic [9:0]  req_words = '0;
    logic        req_autopre = 1'b0;
    logic [7:0]  clk_period_ns = 8'd20;
    logic [15:0] wr_data;
    logic        data_pop, ready, req_reject, dq_oe;
    logic [3:0]  sd_cmd_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_dqm;
    logic [15:0] dq_out;

    sdram_wr_burst_term #(.TRP_CYC(TB_TRP)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_col(req_col),
        .req_rd_col(req_rd_col), .req_row(req_row), .req_blen(req_blen),
        .req_words(req_words), .req_mode(req_mode), .req_autopre(req_autopre),
        .clk_period_ns(clk_period_ns), .wr_data(wr_data), .data_pop(data_pop),
        .ready(ready), .req_reject(req_reject), .sd_cmd_n(sd_cmd_n),
        .sd_addr(sd_addr), .sd_dqm(sd_dqm), .dq_oe(dq_oe), .dq_out(dq_out)
    );

    always #2 clk = ~clk;

    int n_tests = 0, n_fail = 0, cyc = 0, pidx = 0, exp_base = 0;
    bit done = 1'b0;

    function automatic logic [15:0] pay_val(input int i);
        return 16'((i * 4951 + 165) & 16'hFFFF);
    endfunction
    assign wr_data = pay_val(pidx);

    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rst) pidx <= 0; else if (data_pop) pidx <= pidx + 1;

    typedef struct {
        int cyc; logic [3:0] cmd; int addr; bit chk_addr; bit chk_dqm; bit dqm;
        bit oe; logic [15:0] dq; bit rdy; bit rej; string tag;
    } item_t;
    item_t q[$];
    item_t it;

    task automatic push(input int c, input logic [3:0] cmd, input int addr, input bit ca,
                        input bit cm, input bit m, input bit oe, input logic [15:0] dq,
                        input bit rdy, input bit rej, input string tag);
        item_t x;
        x.cyc = c; x.cmd = cmd; x.addr = addr; x.chk_addr = ca; x.chk_dqm = cm;
        x.dqm = m; x.oe = oe; x.dq = dq; x.rdy = rdy; x.rej = rej; x.tag = tag;
        q.push_back(x);
    endtask

    // Monitor: pops the item due this cycle and compares it with the ports.
    always @(negedge clk) begin
        if (!rst) begin
            while (q.size() > 0 && q[0].cyc < cyc) begin
                it = q.pop_front();
                n_tests++; n_fail++;
                $display("FAIL %s: cycle %0d never compared (actual now %0d, expected %0d)",
                         it.tag, it.cyc, cyc, it.cyc);
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                bit bad;
                it = q.pop_front();
                n_tests++;
                bad = (sd_cmd_n != it.cmd) || (dq_oe != it.oe) || (ready != it.rdy) ||
                      (req_reject != it.rej);
                if (it.chk_addr && sd_addr != 13'(it.addr)) bad = 1'b1;
                if (it.chk_dqm && sd_dqm != {2{it.dqm}}) bad = 1'b1;
                if (it.oe && !it.dqm && it.chk_dqm && dq_out != it.dq) bad = 1'b1;
                if (bad) begin
                    n_fail++;
                    $display("FAIL %s cyc %0d: actual cmd=%b addr=%h dqm=%b oe=%b dq=%h rdy=%b rej=%b expected cmd=%b addr=%h dqm=%b oe=%b dq=%h rdy=%b rej=%b",
                             it.tag, cyc, sd_cmd_n, sd_addr, sd_dqm, dq_oe, dq_out, ready, req_reject,
                             it.cmd, 13'(it.addr), {2{it.dqm}}, it.oe, it.dq, it.rdy, it.rej);
                end
            end
        end
    end

    // Driver: waits for ready, issues one request and queues every expected cycle.
    task automatic run_job(input int blen, input int words, input int mode, input bit ap,
                           input int period, input int col, input int rdcol, input int row,
                           input bit ok, input string tag);
        int len, s, twr, p;
        do begin @(posedge clk); #1; end while (!ready);
        req_valid = 1'b1; req_blen = 2'(blen); req_words = 10'(words); req_mode = 2'(mode);
        req_autopre = ap; clk_period_ns = 8'(period); req_col = 9'(col);
        req_rd_col = 9'(rdcol); req_row = 13'(row);
        s = cyc + 1;
        len = (blen == 0) ? 2 : (blen == 1) ? 4 : (blen == 2) ? 8 : 512;
        twr = (period >= 15) ? 1 : 2;
        if (!ok) begin
            push(s, C_NOP, 0, 0, 0, 0, 0, 0, 1, 1, tag);
        end else begin
            for (int k = 0; k < words; k++)
                push(s + k, (k == 0) ? C_WR : C_NOP, col | (int'(ap) << 10), k == 0, 1, 0, 1,
                     pay_val(exp_base + k), (mode == 0 && !ap && k == len - 1), 0, tag);
            exp_base += words;
            p = -1;
            if (mode == 2) begin
                push(s + words, C_RD, rdcol, 1, 0, 0, 0, 0, 0, 0, tag);
                push(s + words + 1, C_NOP, 0, 0, 0, 0, 0, 0, 1, 0, tag);
            end else if (mode == 1) begin
                p = words - 1 + twr;
                for (int k = words; k < p; k++)
                    push(s + k, C_NOP, 0, 0, 1, 1, k < len, 0, 0, 0, tag);
                push(s + p, C_PRE, 0, 1, 1, 1, 0, 0, 0, 0, tag);
            end else begin
                for (int k = words; k < len; k++)
                    push(s + k, C_NOP, 0, 0, 1, 1, 1, 0, (!ap && k == len - 1), 0, tag);
                if (ap) begin
                    p = len - 1 + twr;
                    for (int k = len; k <= p; k++)
                        push(s + k, C_NOP, 0, 0, 0, 0, 0, 0, 0, 0, tag);
                end
            end
            if (p >= 0) begin
                for (int k = 1; k < TB_TRP; k++)
                    push(s + p + k, C_NOP, 0, 0, 0, 0, 0, 0, 0, 0, tag);
                push(s + p + TB_TRP, C_ACT, row, 1, 0, 0, 0, 0, 0, 0, tag);
                push(s + p + TB_TRP + 1, C_NOP, 0, 0, 0, 0, 0, 0, 1, 0, tag);
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        n_tests++;
        if (!(ready && sd_cmd_n == C_NOP && !dq_oe && !req_reject && sd_dqm == 2'b00)) begin
            n_fail++;
            $display("FAIL R1 reset: actual rdy=%b cmd=%b oe=%b rej=%b dqm=%b expected 1 0111 0 0 00",
                     ready, sd_cmd_n, dq_oe, req_reject, sd_dqm);
        end
        run_job(1, 4, 0, 0, 20, 9'h012, 0, 0, 1, "R2 R3 R4 run BL4 full");
        run_job(2, 5, 0, 0, 20, 9'h040, 0, 0, 1, "R4 run BL8 masked tail");
        run_job(0, 2, 0, 0, 5, 9'h100, 0, 0, 1, "R4 R11 run BL2 dqm low");
        run_job(0, 1, 0, 0, 5, 9'h101, 0, 0, 1, "R11 back-to-back write");
        run_job(1, 4, 2, 0, 20, 9'h020, 9'h0A0, 0, 1, "R5 read right after BL4");
        run_job(3, 6, 2, 0, 10, 9'h1F0, 9'h033, 0, 1, "R5 read cuts full page");
        run_job(2, 3, 1, 0, 20, 9'h008, 0, 13'h1234, 1, "R6 R7 R8 pre tWR1");
        run_job(2, 3, 1, 0, 5, 9'h018, 0, 13'h0ABC, 1, "R6 R7 R8 pre tWR2");
        run_job(3, 4, 1, 0, 10, 9'h0F0, 0, 13'h0777, 1, "R6 pre cuts full page");
        run_job(0, 2, 1, 0, 5, 9'h002, 0, 13'h0042, 1, "R6 R7 pre after BL2 tWR2");
        run_job(1, 4, 0, 1, 20, 9'h030, 0, 13'h0321, 1, "R9 autopre tWR1");
        run_job(1, 3, 0, 1, 5, 9'h034, 0, 13'h0654, 1, "R9 autopre tWR2");
        run_job(3, 4, 0, 0, 20, 0, 0, 0, 0, "R10 refuse page run");
        run_job(1, 2, 1, 1, 20, 0, 0, 0, 0, "R10 refuse autopre with pre");
        run_job(1, 0, 0, 0, 20, 0, 0, 0, 0, "R10 refuse zero words");
        run_job(1, 5, 2, 0, 20, 0, 0, 0, 0, "R10 refuse words over burst");
        run_job(2, 2, 3, 0, 20, 0, 0, 0, 0, "R10 refuse mode 3");
        run_job(0, 2, 2, 0, 20, 9'h055, 9'h066, 0, 1, "R3 R5 after refusals");
        while (q.size() > 0) @(posedge clk);
        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule